// File: doc/BRIEF.md
# DDR4 Mode-Register Snoop Shadow File

This block sits beside a DDR4 command bus and keeps a copy of every mode-register-set command it sees. The copies live in a shadow file with one 14-bit entry for each of the seven writable mode registers (MR0 to MR6), repeated for each of four rank pairs, 28 entries in all. Each cycle the decoder looks at the command strobe, the four active-low chip selects, ACT_n, the address lines and the bank and bank-group bits. It decides whether the cycle is a mode-register write and, if so, which entry it targets. The rank pair comes from a small programmable table that maps each chip select to a rank pair.

Snooping can store wrong values on some configurations, for example quad-rank and load-reduced modules. A host register port therefore lets software read any entry and rewrite it. The same port reaches the chip-select map and a per-rank-pair sticky status word. An index outside the file is refused and flagged.

Top module: `mrs_shadow_file`

## Requirements
- R1: An entry is captured only in a cycle where cmd_vld is 1, at least one bit of cmd_cs_n is 0, cmd_act_n is 1, and cmd_addr[16], cmd_addr[15] and cmd_addr[14] are all 0.
- R2: A command with cmd_bg0=1 and cmd_ba=2'b11 (mode register 7) is never captured and changes no entry and no status bit.
- R3: The target mode register is {cmd_bg0, cmd_ba[1], cmd_ba[0]}. The rank pair is the map entry of the lowest-numbered chip select that is low. The map resets to chip select i mapping to rank pair i. A host write with host_kind=2'b01 sets the map entry at index host_rp to host_wdata[1:0].
- R4: The captured payload is cmd_addr[13:0] in reversed order: image bit k holds cmd_addr[13-k]. Image bits 63:14 always read as 0.
- R5: After a host request in one cycle (host_en=1), host_rdata and host_err change at the following rising edge. host_kind=2'b00 returns the shadow image at (host_mr, host_rp). With host_en=0, host_rdata holds its value.
- R6: A host write with host_kind=2'b00 stores host_wdata[13:0] as given into entry (host_mr, host_rp). host_wdata[63:14] is ignored.
- R7: A request with host_rp>=4 (shadow or map kind), host_mr>=7 (shadow kind) or host_kind=2'b11 raises host_err for one cycle after the request, returns host_rdata=0 and changes no state.
- R8: If a snooped capture and a host write target the same entry in the same cycle, the host value is stored.
- R9: Status bit p is set by every captured command whose rank pair is p. It is read with host_kind=2'b10 in bits 3:0 and cleared by writing 1 to it with host_kind=2'b10. A set and a clear of the same bit in the same cycle leave it set.
- R10: After reset all entries and status bits are 0, host_rdata is 0 and host_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_vld | input | 1 | Command bus carries a command this cycle |
| cmd_cs_n | input | 4 | Active-low chip selects |
| cmd_act_n | input | 1 | Activate strobe, active low |
| cmd_addr | input | 17 | Address lines A16..A0 (A16..A14 double as command pins) |
| cmd_ba | input | 2 | Bank address |
| cmd_bg0 | input | 1 | Bank group bit 0 |
| host_en | input | 1 | Host request strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_kind | input | 2 | 00 shadow entry, 01 chip-select map, 10 status, 11 reserved |
| host_mr | input | 3 | Mode register number for shadow accesses |
| host_rp | input | 3 | Rank pair (shadow) or chip-select index (map) |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data, registered |
| host_err | output | 1 | Invalid request flag, one cycle after the request |

## Verification
The embedded assertions watch every cycle for several properties. Mode register 7 never leaves the decoder as a capture. A cycle with ACT_n low is never taken as a capture. The most recent write always lands in its entry, and the host value wins a collision. Map writes stick, status bits stay set until cleared, and an out-of-range rank pair is always flagged with zero read data. Only the bench scenarios show the end-to-end values: the reversed payload order, the lowest-chip-select choice after the map is reprogrammed, and that filtered commands leave every entry and status bit unchanged. They also show that rejected writes do not alias into a valid entry.

// File: rtl/mrs_shadow_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the mode-register shadow file.
// Assumes: the host access kind is a 2-bit field on the host port.
package mrs_shadow_pkg;

    // Which storage a host request addresses
    typedef enum logic [1:0] {
        HK_SHADOW = 2'b00,
        HK_MAP    = 2'b01,
        HK_STATUS = 2'b10,
        HK_RSVD   = 2'b11
    } host_kind_e;

    // Mode register number is formed from {BG0, BA1, BA0}
    localparam int MR_W = 3;

endpackage

// File: rtl/mrs_cmd_decode.sv
`timescale 1ns/1ps
// Module: mrs_cmd_decode
// Recognises a DDR4 mode-register-set command on the command bus. It picks
// the lowest-numbered active chip select and extracts the reversed payload.
// Assumes: A16/A15/A14 act as RAS_n/CAS_n/WE_n when ACT_n is high, and the
// bank code {BG0,BA1,BA0}=7 is the register-control word, which is excluded.
module mrs_cmd_decode #(
    parameter int NUM_CS    = 4,
    parameter int ADDR_W    = 17,
    parameter int PAYLOAD_W = 14,
    parameter int MR_W      = 3,
    parameter int CS_W      = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_vld,
    input  logic [NUM_CS-1:0]    cmd_cs_n,
    input  logic                 cmd_act_n,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [1:0]           cmd_ba,
    input  logic                 cmd_bg0,
    output logic                 is_mrs,
    output logic [MR_W-1:0]      mr_idx,
    output logic [CS_W-1:0]      cs_idx,
    output logic [PAYLOAD_W-1:0] payload
);
    localparam int RAS_BIT = ADDR_W - 1;
    localparam int CAS_BIT = ADDR_W - 2;
    localparam int WE_BIT  = ADDR_W - 3;

    logic any_cs;
    logic cmd_is_mrs;
    logic code_is_rcw;

    // Lowest-numbered low chip select wins (scan from the top so low overrides)
    always_comb begin
        cs_idx = '0;
        any_cs = 1'b0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (!cmd_cs_n[i]) begin
                cs_idx = CS_W'(i);
                any_cs = 1'b1;
            end
        end
    end

    // Command pin pattern and excluded bank code
    always_comb begin
        cmd_is_mrs  = cmd_act_n & ~cmd_addr[RAS_BIT] & ~cmd_addr[CAS_BIT] & ~cmd_addr[WE_BIT];
        code_is_rcw = cmd_bg0 & cmd_ba[1] & cmd_ba[0];
        is_mrs      = cmd_vld & any_cs & cmd_is_mrs & ~code_is_rcw;
        mr_idx      = {cmd_bg0, cmd_ba[1], cmd_ba[0]};
    end

    // Payload bit order is reversed against the address numbering
    for (genvar g = 0; g < PAYLOAD_W; g++) begin : g_rev
        assign payload[g] = cmd_addr[PAYLOAD_W-1-g];
    end

    // R2: the register-control code never reaches the shadow file
    a_r2_no_rcw_capture: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (mr_idx != {MR_W{1'b1}}));

    // R1: an activate cycle is never taken as a mode-register write
    a_r1_act_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && !cmd_act_n) |-> !is_mrs);

endmodule

// File: rtl/mrs_cs_map.sv
`timescale 1ns/1ps
// Module: mrs_cs_map
// Programmable table that maps each chip select to a rank pair.
// Assumes: at reset chip select i maps to rank pair i modulo the pair count.
module mrs_cs_map #(
    parameter int NUM_CS = 4,
    parameter int NUM_RP = 4,
    parameter int CS_W   = 2,
    parameter int RP_W   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CS_W-1:0] wr_idx,
    input  logic [RP_W-1:0] wr_rp,
    input  logic [CS_W-1:0] lookup_idx,
    output logic [RP_W-1:0] lookup_rp,
    input  logic [CS_W-1:0] rd_idx,
    output logic [RP_W-1:0] rd_rp
);
    logic [RP_W-1:0] map_q [NUM_CS];

    // Table storage with identity reset
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CS; i++) begin
            if (!rst_n)
                map_q[i] <= RP_W'(i % NUM_RP);
            else if (wr_en && (wr_idx == CS_W'(i)))
                map_q[i] <= wr_rp;
        end
    end

    // Two independent read ports: snoop lookup and host read
    always_comb begin
        lookup_rp = map_q[lookup_idx];
        rd_rp     = map_q[rd_idx];
    end

    // R3: a map write is visible at the next edge
    a_r3_map_write_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (map_q[$past(wr_idx)] == $past(wr_rp)));

endmodule

// File: rtl/mrs_shadow_bank.sv
`timescale 1ns/1ps
// Module: mrs_shadow_bank
// Payload storage for every (rank pair, mode register) pair, with a snoop
// write port, a host write port that wins on collision, and a host read port.
// Assumes: callers only present in-range indices on the write ports.
module mrs_shadow_bank #(
    parameter int NUM_RP    = 4,
    parameter int NUM_MR    = 7,
    parameter int PAYLOAD_W = 14,
    parameter int RP_W      = 2,
    parameter int MR_W      = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 snoop_we,
    input  logic [RP_W-1:0]      snoop_rp,
    input  logic [MR_W-1:0]      snoop_mr,
    input  logic [PAYLOAD_W-1:0] snoop_data,
    input  logic                 host_we,
    input  logic [RP_W-1:0]      host_rp,
    input  logic [MR_W-1:0]      host_mr,
    input  logic [PAYLOAD_W-1:0] host_data,
    input  logic [RP_W-1:0]      rd_rp,
    input  logic [MR_W-1:0]      rd_mr,
    output logic [PAYLOAD_W-1:0] rd_data
);
    localparam int NUM_ENT = NUM_RP * NUM_MR;
    localparam int ENT_W   = $clog2(NUM_ENT);

    logic [PAYLOAD_W-1:0] mem [NUM_ENT];
    logic [ENT_W-1:0]     snoop_idx, host_idx, rd_idx;

    // Flatten (rank pair, mode register) into an entry number
    always_comb begin
        snoop_idx = ENT_W'(int'(snoop_rp) * NUM_MR + int'(snoop_mr));
        host_idx  = ENT_W'(int'(host_rp)  * NUM_MR + int'(host_mr));
        rd_idx    = ENT_W'(int'(rd_rp)    * NUM_MR + int'(rd_mr));
    end

    // Entry update: host write takes priority over snoop capture
    always_ff @(posedge clk) begin
        for (int e = 0; e < NUM_ENT; e++) begin
            if (!rst_n)
                mem[e] <= '0;
            else if (host_we && (host_idx == ENT_W'(e)))
                mem[e] <= host_data;
            else if (snoop_we && (snoop_idx == ENT_W'(e)))
                mem[e] <= snoop_data;
        end
    end

    // Host read mux, guarded against indices past the file
    always_comb begin
        rd_data = (rd_idx < ENT_W'(NUM_ENT)) ? mem[rd_idx] : '0;
    end

    // Checker state: remembers the winning write of the last cycle
    logic                 chk_vld;
    logic [ENT_W-1:0]     chk_idx;
    logic [PAYLOAD_W-1:0] chk_data;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_vld  <= 1'b0;
            chk_idx  <= '0;
            chk_data <= '0;
        end else begin
            chk_vld  <= host_we | snoop_we;
            chk_idx  <= host_we ? host_idx  : snoop_idx;
            chk_data <= host_we ? host_data : snoop_data;
        end
    end

    // R6: the last accepted write is what the entry holds
    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        chk_vld |-> (mem[chk_idx] == chk_data));

    // R8: same-entry collision keeps the host value
    a_r8_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && snoop_we && host_idx == snoop_idx) |=> (mem[$past(host_idx)] == $past(host_data)));

endmodule

// File: rtl/mrs_pair_status.sv
`timescale 1ns/1ps
// Module: mrs_pair_status
// One sticky flag per rank pair, set by snooped captures and cleared by a
// write-one-to-clear mask. A set in the same cycle as a clear wins.
module mrs_pair_status #(
    parameter int NUM_RP = 4,
    parameter int RP_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [RP_W-1:0]   set_rp,
    input  logic [NUM_RP-1:0] clr_mask,
    output logic [NUM_RP-1:0] status
);
    logic [NUM_RP-1:0] set_vec;

    // Decode the capture into a one-hot set vector
    always_comb begin
        set_vec = '0;
        if (set_en) set_vec[set_rp] = 1'b1;
    end

    // Sticky flags, set dominant over clear
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_mask) | set_vec;
    end

    // R9: a flag that is not cleared never drops
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status) & ~$past(clr_mask)) & ~status) == '0));

    // R9: a capture always leaves its pair flagged
    a_r9_set_seen: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> status[$past(set_rp)]);

endmodule

// File: rtl/mrs_shadow_file.sv
`timescale 1ns/1ps
// Module: mrs_shadow_file (top)
// Snoops the DDR4 command bus for mode-register writes and keeps a shadow
// copy per rank pair. A host port reads or rewrites entries, the chip-select
// map and the status flags. Invalid host indices are refused with host_err.
// Assumes: the host drives one request per cycle; read data is registered.
module mrs_shadow_file
    import mrs_shadow_pkg::*;
#(
    parameter int NUM_CS    = 4,
    parameter int NUM_RP    = 4,
    parameter int NUM_MR    = 7,
    parameter int PAYLOAD_W = 14,
    parameter int IMG_W     = 64,
    parameter int ADDR_W    = 17
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_vld,
    input  logic [NUM_CS-1:0]         cmd_cs_n,
    input  logic                      cmd_act_n,
    input  logic [ADDR_W-1:0]         cmd_addr,
    input  logic [1:0]                cmd_ba,
    input  logic                      cmd_bg0,
    input  logic                      host_en,
    input  logic                      host_we,
    input  logic [1:0]                host_kind,
    input  logic [2:0]                host_mr,
    input  logic [$clog2(NUM_RP):0]   host_rp,
    input  logic [IMG_W-1:0]          host_wdata,
    output logic [IMG_W-1:0]          host_rdata,
    output logic                      host_err
);
    localparam int RP_W  = $clog2(NUM_RP);
    localparam int RPX_W = RP_W + 1;
    localparam int CS_W  = $clog2(NUM_CS);
    localparam logic [RPX_W-1:0] RP_LIMIT = RPX_W'(NUM_RP);
    localparam logic [RPX_W-1:0] CS_LIMIT = RPX_W'(NUM_CS);
    localparam logic [2:0]       MR_LIMIT = 3'(NUM_MR);

    // Snoop path wires
    logic                 snp_mrs;
    logic [MR_W-1:0]      snp_mr;
    logic [CS_W-1:0]      snp_cs;
    logic [PAYLOAD_W-1:0] snp_payload;
    logic [RP_W-1:0]      snp_rp;

    // Host path wires
    host_kind_e           kind;
    logic                 req_ok;
    logic                 wr_shadow, wr_map, wr_status;
    logic [PAYLOAD_W-1:0] bank_rd;
    logic [RP_W-1:0]      map_rd;
    logic [NUM_RP-1:0]    status;
    logic [NUM_RP-1:0]    clr_mask;
    logic [IMG_W-1:0]     rd_mux;
    logic                 unused_wdata;

    mrs_cmd_decode #(
        .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .PAYLOAD_W(PAYLOAD_W), .MR_W(MR_W), .CS_W(CS_W)
    ) u_decode (
        .clk(clk), .rst_n(rst_n),
        .cmd_vld(cmd_vld), .cmd_cs_n(cmd_cs_n), .cmd_act_n(cmd_act_n),
        .cmd_addr(cmd_addr), .cmd_ba(cmd_ba), .cmd_bg0(cmd_bg0),
        .is_mrs(snp_mrs), .mr_idx(snp_mr), .cs_idx(snp_cs), .payload(snp_payload)
    );

    // Classify the host request and check its indices
    always_comb begin
        kind = host_kind_e'(host_kind);
        unique case (kind)
            HK_SHADOW: req_ok = (host_rp < RP_LIMIT) && (host_mr < MR_LIMIT);
            HK_MAP:    req_ok = (host_rp < CS_LIMIT);
            HK_STATUS: req_ok = 1'b1;
            default:   req_ok = 1'b0;
        endcase
        wr_shadow = host_en && host_we && req_ok && (kind == HK_SHADOW);
        wr_map    = host_en && host_we && req_ok && (kind == HK_MAP);
        wr_status = host_en && host_we && req_ok && (kind == HK_STATUS);
        clr_mask  = wr_status ? host_wdata[NUM_RP-1:0] : '0;
    end

    assign unused_wdata = ^host_wdata[IMG_W-1:PAYLOAD_W];

    mrs_cs_map #(
        .NUM_CS(NUM_CS), .NUM_RP(NUM_RP), .CS_W(CS_W), .RP_W(RP_W)
    ) u_map (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_map), .wr_idx(host_rp[CS_W-1:0]), .wr_rp(host_wdata[RP_W-1:0]),
        .lookup_idx(snp_cs), .lookup_rp(snp_rp),
        .rd_idx(host_rp[CS_W-1:0]), .rd_rp(map_rd)
    );

    mrs_shadow_bank #(
        .NUM_RP(NUM_RP), .NUM_MR(NUM_MR), .PAYLOAD_W(PAYLOAD_W), .RP_W(RP_W), .MR_W(MR_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .snoop_we(snp_mrs), .snoop_rp(snp_rp), .snoop_mr(snp_mr), .snoop_data(snp_payload),
        .host_we(wr_shadow), .host_rp(host_rp[RP_W-1:0]), .host_mr(host_mr),
        .host_data(host_wdata[PAYLOAD_W-1:0]),
        .rd_rp(host_rp[RP_W-1:0]), .rd_mr(host_mr), .rd_data(bank_rd)
    );

    mrs_pair_status #(
        .NUM_RP(NUM_RP), .RP_W(RP_W)
    ) u_status (
        .clk(clk), .rst_n(rst_n),
        .set_en(snp_mrs), .set_rp(snp_rp), .clr_mask(clr_mask), .status(status)
    );

    // Select the 64-bit image for the addressed storage
    always_comb begin
        rd_mux = '0;
        unique case (kind)
            HK_SHADOW: rd_mux[PAYLOAD_W-1:0] = bank_rd;
            HK_MAP:    rd_mux[RP_W-1:0]      = map_rd;
            HK_STATUS: rd_mux[NUM_RP-1:0]    = status;
            default:   rd_mux = '0;
        endcase
    end

    // Registered host response: data and error flag one cycle after request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
            host_err   <= 1'b0;
        end else begin
            host_err <= host_en && !req_ok;
            if (host_en) host_rdata <= req_ok ? rd_mux : '0;
        end
    end

    // R7: an out-of-range rank pair is flagged with zero data
    a_r7_bad_rp_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (host_en && host_rp >= RP_LIMIT && host_kind != 2'b10) |=> (host_err && host_rdata == '0));

    // R5: read data holds while no request is made
    a_r5_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !host_en |=> $stable(host_rdata));

    // R4: upper image bits of a shadow read are always zero
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_en && host_kind == 2'b00) |=> (host_rdata[IMG_W-1:PAYLOAD_W] == '0));

endmodule

// File: tb/mrs_shadow_file_tb.sv
`timescale 1ns/1ps
// Directed bench for mrs_shadow_file: one task per scenario.
module mrs_shadow_file_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_vld = 1'b0;
    logic [3:0]  cmd_cs_n = 4'hF;
    logic        cmd_act_n = 1'b1;
    logic [16:0] cmd_addr = '0;
    logic [1:0]  cmd_ba = '0;
    logic        cmd_bg0 = 1'b0;
    logic        host_en = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_kind = '0;
    logic [2:0]  host_mr = '0;
    logic [2:0]  host_rp = '0;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;
    logic        host_err;

    int checks = 0;
    int errors = 0;
    logic [63:0] rd_v;
    logic        er_v;

    always #2 clk = ~clk;

    mrs_shadow_file u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_cs_n(cmd_cs_n),
        .cmd_act_n(cmd_act_n), .cmd_addr(cmd_addr), .cmd_ba(cmd_ba), .cmd_bg0(cmd_bg0),
        .host_en(host_en), .host_we(host_we), .host_kind(host_kind), .host_mr(host_mr),
        .host_rp(host_rp), .host_wdata(host_wdata), .host_rdata(host_rdata), .host_err(host_err)
    );

    function automatic logic [63:0] rev_img(input logic [13:0] p);
        logic [63:0] r = '0;
        for (int k = 0; k < 14; k++) r[k] = p[13-k];
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One host request; result captured after the following edge
    task automatic host_op(input logic [1:0] kind, input logic we, input logic [2:0] mr,
                           input logic [2:0] rp, input logic [63:0] wd);
        @(negedge clk);
        host_en = 1'b1; host_we = we; host_kind = kind; host_mr = mr; host_rp = rp; host_wdata = wd;
        @(negedge clk);
        rd_v = host_rdata; er_v = host_err;
        host_en = 1'b0; host_we = 1'b0;
    endtask

    task automatic rd_entry(input logic [2:0] mr, input logic [2:0] rp);
        host_op(2'b00, 1'b0, mr, rp, '0);
    endtask

    // One command-bus cycle
    task automatic snoop(input logic vld, input logic [3:0] cs_n, input logic act_n,
                         input logic [16:0] addr, input logic bg0, input logic [1:0] ba);
        @(negedge clk);
        cmd_vld = vld; cmd_cs_n = cs_n; cmd_act_n = act_n; cmd_addr = addr; cmd_bg0 = bg0; cmd_ba = ba;
        @(negedge clk);
        cmd_vld = 1'b0; cmd_cs_n = 4'hF;
    endtask

    task automatic t_reset;
        rd_entry(3'd0, 3'd0);
        check("R10 entry zero", rd_v, 64'h0);
        check("R10 err low", {63'h0, er_v}, 64'h0);
        host_op(2'b10, 1'b0, 3'd0, 3'd0, '0);
        check("R10 status zero", rd_v, 64'h0);
        host_op(2'b01, 1'b0, 3'd0, 3'd2, '0);
        check("R10 map identity", rd_v, 64'd2);
    endtask

    task automatic t_basic;
        snoop(1'b1, 4'b1110, 1'b1, {3'b000, 14'h1235}, 1'b0, 2'b00);
        rd_entry(3'd0, 3'd0);
        check("R4 reversed payload mr0 rp0", rd_v, rev_img(14'h1235));
        snoop(1'b1, 4'b1011, 1'b1, {3'b000, 14'h2ABC}, 1'b1, 2'b10);
        rd_entry(3'd6, 3'd2);
        check("R1 capture mr6 rp2", rd_v, rev_img(14'h2ABC));
        host_op(2'b10, 1'b0, 3'd0, 3'd0, '0);
        check("R9 status after captures", rd_v, 64'h5);
    endtask

    task automatic t_filter;
        host_op(2'b10, 1'b1, 3'd0, 3'd0, 64'hF);
        snoop(1'b0, 4'b1110, 1'b1, {3'b000, 14'h3FFF}, 1'b0, 2'b01);
        snoop(1'b1, 4'b1111, 1'b1, {3'b000, 14'h3FFF}, 1'b0, 2'b01);
        snoop(1'b1, 4'b1110, 1'b0, {3'b000, 14'h3FFF}, 1'b0, 2'b01);
        snoop(1'b1, 4'b1110, 1'b1, {3'b100, 14'h3FFF}, 1'b0, 2'b01);
        snoop(1'b1, 4'b1110, 1'b1, {3'b010, 14'h3FFF}, 1'b0, 2'b01);
        snoop(1'b1, 4'b1110, 1'b1, {3'b001, 14'h3FFF}, 1'b0, 2'b01);
        rd_entry(3'd1, 3'd0);
        check("R1 non-MRS cycles ignored", rd_v, 64'h0);
        host_op(2'b10, 1'b0, 3'd0, 3'd0, '0);
        check("R1 status untouched by non-MRS", rd_v, 64'h0);
        snoop(1'b1, 4'b1110, 1'b1, {3'b000, 14'h3FFF}, 1'b1, 2'b11);
        host_op(2'b10, 1'b0, 3'd0, 3'd0, '0);
        check("R2 mr7 sets no status", rd_v, 64'h0);
        rd_entry(3'd0, 3'd1);
        check("R2 mr7 does not alias", rd_v, 64'h0);
    endtask

    task automatic t_map;
        snoop(1'b1, 4'b1001, 1'b1, {3'b000, 14'h0F0F}, 1'b1, 2'b01);
        rd_entry(3'd5, 3'd1);
        check("R3 lowest cs picks rp1", rd_v, rev_img(14'h0F0F));
        rd_entry(3'd5, 3'd2);
        check("R3 higher cs not used", rd_v, 64'h0);
        host_op(2'b01, 1'b1, 3'd0, 3'd1, 64'd3);
        host_op(2'b01, 1'b0, 3'd0, 3'd1, '0);
        check("R3 map readback", rd_v, 64'd3);
        snoop(1'b1, 4'b1101, 1'b1, {3'b000, 14'h1111}, 1'b0, 2'b10);
        rd_entry(3'd2, 3'd3);
        check("R3 remapped cs1 to rp3", rd_v, rev_img(14'h1111));
    endtask

    task automatic t_host_write;
        host_op(2'b00, 1'b1, 3'd3, 3'd2, 64'hFFFF_0000_0000_2468);
        rd_entry(3'd3, 3'd2);
        check("R6 host write low bits only", rd_v, 64'h2468);
        check("R5 read err low", {63'h0, er_v}, 64'h0);
    endtask

    task automatic t_invalid;
        host_op(2'b00, 1'b1, 3'd3, 3'd4, 64'h1555);
        check("R7 rp4 write err", {63'h0, er_v}, 64'h1);
        check("R7 rp4 write data zero", rd_v, 64'h0);
        rd_entry(3'd3, 3'd0);
        check("R7 rp4 no alias to rp0", rd_v, 64'h0);
        rd_entry(3'd2, 3'd5);
        check("R7 rp5 read err", {63'h0, er_v}, 64'h1);
        rd_entry(3'd7, 3'd0);
        check("R7 mr7 read err", {63'h0, er_v}, 64'h1);
        check("R7 mr7 read data zero", rd_v, 64'h0);
        host_op(2'b11, 1'b0, 3'd0, 3'd0, '0);
        check("R7 reserved kind err", {63'h0, er_v}, 64'h1);
        host_op(2'b01, 1'b1, 3'd0, 3'd4, 64'd3);
        check("R7 map idx4 err", {63'h0, er_v}, 64'h1);
        host_op(2'b01, 1'b0, 3'd0, 3'd0, '0);
        check("R7 map idx0 unchanged", rd_v, 64'd0);
        check("R7 err clears on valid", {63'h0, er_v}, 64'h0);
    endtask

    task automatic t_collision;
        @(negedge clk);
        cmd_vld = 1'b1; cmd_cs_n = 4'b1110; cmd_act_n = 1'b1; cmd_addr = {3'b000, 14'h0001};
        cmd_bg0 = 1'b1; cmd_ba = 2'b00;
        host_en = 1'b1; host_we = 1'b1; host_kind = 2'b00; host_mr = 3'd4; host_rp = 3'd0;
        host_wdata = 64'h0ABC;
        @(negedge clk);
        cmd_vld = 1'b0; cmd_cs_n = 4'hF; host_en = 1'b0; host_we = 1'b0;
        rd_entry(3'd4, 3'd0);
        check("R8 host wins collision", rd_v, 64'h0ABC);
    endtask

    task automatic t_status;
        host_op(2'b10, 1'b1, 3'd0, 3'd0, 64'hF);
        host_op(2'b10, 1'b0, 3'd0, 3'd0, '0);
        check("R9 clear all", rd_v, 64'h0);
        snoop(1'b1, 4'b0111, 1'b1, {3'b000, 14'h0002}, 1'b0, 2'b01);
        host_op(2'b10, 1'b1, 3'd0, 3'd0, 64'h1);
        host_op(2'b10, 1'b0, 3'd0, 3'd0, '0);
        check("R9 clear of unset bit keeps rp3", rd_v, 64'h8);
        @(negedge clk);
        cmd_vld = 1'b1; cmd_cs_n = 4'b1110; cmd_act_n = 1'b1; cmd_addr = {3'b000, 14'h0003};
        cmd_bg0 = 1'b0; cmd_ba = 2'b01;
        host_en = 1'b1; host_we = 1'b1; host_kind = 2'b10; host_wdata = 64'h1;
        @(negedge clk);
        cmd_vld = 1'b0; cmd_cs_n = 4'hF; host_en = 1'b0; host_we = 1'b0;
        host_op(2'b10, 1'b0, 3'd0, 3'd0, '0);
        check("R9 set beats clear", rd_v, 64'h9);
        host_op(2'b10, 1'b1, 3'd0, 3'd0, 64'h8);
        host_op(2'b10, 1'b0, 3'd0, 3'd0, '0);
        check("R9 w1c clears rp3 only", rd_v, 64'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_filter();
        t_map();
        t_host_write();
        t_invalid();
        t_collision();
        t_status();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule